// File: doc/BRIEF.md
# Display Channel Two-Wire Slave with Mode Control

This peripheral lets a small controller answer a display host over a two-wire serial link (clock and data lines, I2C-style signalling). Out of reset it sits in the legacy one-way mode and keeps its line function switched off. Firmware first turns the line function on. From then on, the first START condition seen on the bus moves the block into the bidirectional addressed mode. The hardware clears the mode bit by itself when this happens.

In the bidirectional mode the block watches for START and STOP conditions and compares the first byte of each transfer against a programmable 7-bit address. It acknowledges a matching address and every byte it receives. In read direction it shifts the data buffer out, most significant bit first, and then records whether the host acknowledged. Three interrupt sources exist: address hit, byte done and stop. Each has an enable bit, a pending flag and a write-1-to-clear bit. A sticky STOP status bit lets firmware poll instead of taking interrupts. Firmware can force the legacy mode back on while the clock line is high, which is the error recovery path.

The bus data line is open drain. The block only ever pulls it low, through `sda_oe`.

Top module: `ddcx_slave`

## Requirements
- R1: After reset the registers read: CONTROL (offset 0) = 0x03 (bit 0 legacy mode = 1, bit 1 line function off = 1), IRQ_ENABLE (1) = 0x00, IRQ_PENDING (2) = 0x00, IRQ_CLEAR (3) = 0x00, OWN_ADDRESS (4) = 0xFF, DATA (5) = 0x00, STATUS (6) = 0x00, offset 7 = 0x00. After reset `pin_sel`, `sda_oe` and `irq` are 0.
- R2: While the line function is on, a START (data falls while clock is high) clears CONTROL bit 0 to 0 in hardware. This holds even though firmware can never write that bit to 0.
- R3: Writing 1 to CONTROL bit 0 sets legacy mode only if the synchronized clock line is high at the write. If the clock line is low, the write leaves the bit at 0.
- R4: The address byte is matched on its upper seven bits against OWN_ADDRESS bits 7..1, and bit 0 of the byte gives the direction (1 = read). On a match the block pulls data low during the ninth clock and sets IRQ_PENDING bit 2. On a mismatch it leaves the line released, sets no flag, and waits for the next START.
- R5: In write direction each received byte is stored in DATA and acknowledged during the ninth clock, and IRQ_PENDING bit 1 is set.
- R6: In read direction with STATUS bit 0 (transmit enable) = 1, DATA is driven MSB first, and it is reloaded after every byte the host acknowledges. With STATUS bit 0 = 0 the line is not driven and the host reads 0xFF.
- R7: After each transmitted byte the host's ninth-bit response is stored in STATUS bit 1 (1 = acknowledged) and IRQ_PENDING bit 1 is set. After a not-acknowledge the block releases the line until the next START.
- R8: A STOP (data rises while clock is high) sets STATUS bit 2 and IRQ_PENDING bit 0. STATUS bit 2 stays 1 until firmware writes 1 to it.
- R9: Writing 1 to a bit of IRQ_CLEAR clears that pending flag. `irq` is high when any pending flag has its IRQ_ENABLE bit set (bit 0 stop, bit 1 byte done, bit 2 address hit).
- R10: While CONTROL bit 1 = 1, `pin_sel` is 0, the block never drives the data line, sets no flags and keeps the mode bit unchanged. While it is 0, `pin_sel` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register offset |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |
| scl_in | input | 1 | Bus clock line level |
| sda_in | input | 1 | Bus data line level |
| sda_oe | output | 1 | Pull data line low when 1 |
| pin_sel | output | 1 | Shared port pins switched to bus function |
| irq | output | 1 | Combined interrupt request |

## Verification
The checker watches several rules on every cycle. The mode bit may drop only in the cycle after a recognized START, and it may rise only after a write made while the clock line was high. The sticky STOP bit cannot fall without a clearing write. `irq` cannot be high without an enabled, pending source. The mode bit cannot change while the line function is off. Only the bench scenarios can show that the block acknowledges the right addresses and bytes, shifts out the data buffer in the right bit order, reloads it after each acknowledged byte, and records the host's acknowledge.

// File: rtl/ddcx_pkg.sv
package ddcx_pkg;
    localparam int REG_AW = 3;
    localparam int DW     = 8;
    localparam int BITS_PER_BYTE = 8;

    localparam logic [REG_AW-1:0] OFF_CTRL = 3'd0;
    localparam logic [REG_AW-1:0] OFF_IEN  = 3'd1;
    localparam logic [REG_AW-1:0] OFF_PEND = 3'd2;
    localparam logic [REG_AW-1:0] OFF_ICLR = 3'd3;
    localparam logic [REG_AW-1:0] OFF_SADR = 3'd4;
    localparam logic [REG_AW-1:0] OFF_DATA = 3'd5;
    localparam logic [REG_AW-1:0] OFF_STAT = 3'd6;

    localparam int BIT_LEGACY = 0;
    localparam int BIT_OFF    = 1;
    localparam int BIT_TXDIR  = 0;
    localparam int BIT_RXACK  = 1;
    localparam int BIT_STOP   = 2;

    typedef enum logic [2:0] {
        ST_IDLE, ST_ADDR, ST_AACK, ST_RX, ST_RACK, ST_TX, ST_TACK
    } eng_st_t;

    // bit 2 address hit, bit 1 byte done, bit 0 stop
    typedef struct packed {
        logic addr_hit;
        logic byte_done;
        logic stop;
    } ev_t;

    function automatic logic addr_match(input logic [DW-1:0] rx, input logic [DW-2:0] own);
        return rx[DW-1:1] == own;
    endfunction
endpackage

// File: rtl/ddcx_sync.sv
module ddcx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic scl_in,
    input  logic sda_in,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start,
    output logic stop
);
    logic [1:0] raw;
    logic [1:0] synced;
    logic [1:0] prev;

    assign raw = {sda_in, scl_in};

    for (genvar g = 0; g < 2; g++) begin : g_line
        logic [STAGES-1:0] chain;
        always_ff @(posedge clk) begin
            if (rst) chain <= '1;
            else     chain <= {chain[STAGES-2:0], raw[g]};
        end
        assign synced[g] = chain[STAGES-1];
    end

    always_ff @(posedge clk) begin
        if (rst) prev <= 2'b11;
        else     prev <= synced;
    end

    assign scl_s    = synced[0];
    assign sda_s    = synced[1];
    assign scl_rise = synced[0] & ~prev[0];
    assign scl_fall = ~synced[0] & prev[0];
    assign start    = synced[0] & prev[0] & prev[1] & ~synced[1];
    assign stop     = synced[0] & prev[0] & ~prev[1] & synced[1];
endmodule

// File: rtl/ddcx_engine.sv
module ddcx_engine
    import ddcx_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          en,
    input  logic          legacy,
    input  logic          sda_s,
    input  logic          scl_rise,
    input  logic          scl_fall,
    input  logic          start,
    input  logic          stop,
    input  logic [DW-2:0] own_addr,
    input  logic [DW-1:0] tx_byte,
    input  logic          tx_dir,
    output ev_t           ev,
    output logic [DW-1:0] rx_byte,
    output logic          rx_we,
    output logic          ack_we,
    output logic          ack_val,
    output logic          sda_oe
);
    localparam int CW = $clog2(BITS_PER_BYTE + 1);
    localparam logic [CW-1:0] LAST = CW'(BITS_PER_BYTE);

    eng_st_t       st;
    logic [CW-1:0] cnt;
    logic [DW-1:0] sh;
    logic          rw;

    always_ff @(posedge clk) begin
        if (rst) begin
            st <= ST_IDLE; cnt <= '0; sh <= '0; rw <= 1'b0;
            ev <= '0; rx_we <= 1'b0; ack_we <= 1'b0; ack_val <= 1'b0;
        end else begin
            ev <= '0; rx_we <= 1'b0; ack_we <= 1'b0;
            if (!en) begin
                st <= ST_IDLE;
            end else if (start) begin
                st <= ST_ADDR; cnt <= '0;
            end else if (stop) begin
                st <= ST_IDLE; ev.stop <= 1'b1;
            end else if (legacy) begin
                st <= ST_IDLE;
            end else begin
                unique case (st)
                    ST_ADDR, ST_RX: begin
                        if (scl_rise) begin
                            sh <= {sh[DW-2:0], sda_s}; cnt <= cnt + 1'b1;
                        end else if (scl_fall && cnt == LAST) begin
                            if (st == ST_RX) begin
                                rx_we <= 1'b1; ev.byte_done <= 1'b1; st <= ST_RACK;
                            end else if (addr_match(sh, own_addr)) begin
                                rw <= sh[0]; ev.addr_hit <= 1'b1; st <= ST_AACK;
                            end else begin
                                st <= ST_IDLE;
                            end
                        end
                    end
                    ST_AACK: if (scl_fall) begin
                        cnt <= '0;
                        if (rw) begin st <= ST_TX; sh <= tx_byte; end
                        else    st <= ST_RX;
                    end
                    ST_RACK: if (scl_fall) begin
                        cnt <= '0; st <= ST_RX;
                    end
                    ST_TX: begin
                        if (scl_rise) cnt <= cnt + 1'b1;
                        else if (scl_fall) begin
                            if (cnt == LAST) st <= ST_TACK;
                            else             sh <= {sh[DW-2:0], 1'b0};
                        end
                    end
                    ST_TACK: begin
                        if (scl_rise) begin
                            ack_we <= 1'b1; ack_val <= ~sda_s; ev.byte_done <= 1'b1;
                        end else if (scl_fall) begin
                            if (ack_val) begin st <= ST_TX; sh <= tx_byte; cnt <= '0; end
                            else         st <= ST_IDLE;
                        end
                    end
                    default: st <= ST_IDLE;
                endcase
            end
        end
    end

    assign rx_byte = sh;

    always_comb begin
        unique case (st)
            ST_AACK, ST_RACK: sda_oe = 1'b1;
            ST_TX:            sda_oe = tx_dir & ~sh[DW-1];
            default:          sda_oe = 1'b0;
        endcase
    end
endmodule

// File: rtl/ddcx_regs.sv
module ddcx_regs
    import ddcx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [DW-1:0]     reg_wdata,
    output logic [DW-1:0]     reg_rdata,
    input  logic              scl_s,
    input  logic              start_ev,
    input  ev_t               ev,
    input  logic [DW-1:0]     rx_byte,
    input  logic              rx_we,
    input  logic              ack_we,
    input  logic              ack_val,
    output logic              legacy,
    output logic              off,
    output logic [DW-2:0]     own_addr,
    output logic [DW-1:0]     data_q,
    output logic              tx_dir,
    output logic              stop_flag,
    output logic [2:0]        pend,
    output logic [2:0]        ien,
    output logic              irq
);
    logic       rx_ack;
    logic [2:0] clr;

    function automatic logic hit(input logic [REG_AW-1:0] off_sel);
        return reg_wr && reg_addr == off_sel;
    endfunction

    assign clr = hit(OFF_ICLR) ? reg_wdata[2:0] : 3'b000;

    always_ff @(posedge clk) begin
        if (rst) begin
            legacy <= 1'b1; off <= 1'b1; ien <= '0; pend <= '0;
            own_addr <= '1; data_q <= '0; tx_dir <= 1'b0;
            rx_ack <= 1'b0; stop_flag <= 1'b0;
        end else begin
            if (hit(OFF_CTRL)) begin
                off <= reg_wdata[BIT_OFF];
                if (reg_wdata[BIT_LEGACY] && scl_s) legacy <= 1'b1;
            end
            if (start_ev) legacy <= 1'b0;

            if (hit(OFF_IEN))  ien      <= reg_wdata[2:0];
            if (hit(OFF_SADR)) own_addr <= reg_wdata[DW-1:1];

            pend <= (pend & ~clr) | ev;

            if (hit(OFF_DATA)) data_q <= reg_wdata;
            if (rx_we)         data_q <= rx_byte;

            if (hit(OFF_STAT)) begin
                tx_dir <= reg_wdata[BIT_TXDIR];
                if (reg_wdata[BIT_STOP]) stop_flag <= 1'b0;
            end
            if (ev.stop) stop_flag <= 1'b1;
            if (ack_we)  rx_ack    <= ack_val;
        end
    end

    always_comb begin
        unique case (reg_addr)
            OFF_CTRL: reg_rdata = {6'b0, off, legacy};
            OFF_IEN:  reg_rdata = {5'b0, ien};
            OFF_PEND: reg_rdata = {5'b0, pend};
            OFF_SADR: reg_rdata = {own_addr, 1'b1};
            OFF_DATA: reg_rdata = data_q;
            OFF_STAT: reg_rdata = {5'b0, stop_flag, rx_ack, tx_dir};
            default:  reg_rdata = '0;
        endcase
    end

    assign irq = |(pend & ien);
endmodule

// File: rtl/ddcx_slave.sv
module ddcx_slave
    import ddcx_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       reg_wr,
    input  logic [2:0] reg_addr,
    input  logic [7:0] reg_wdata,
    output logic [7:0] reg_rdata,
    input  logic       scl_in,
    input  logic       sda_in,
    output logic       sda_oe,
    output logic       pin_sel,
    output logic       irq
);
    logic scl_s, sda_s, scl_rise, scl_fall, start, stop, start_ev;
    logic legacy, off, tx_dir, stop_flag, rx_we, ack_we, ack_val, eng_oe;
    logic [DW-2:0] own_addr;
    logic [DW-1:0] data_q, rx_byte;
    logic [2:0]    pend, ien;
    ev_t           ev;

    ddcx_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .scl_in(scl_in), .sda_in(sda_in),
        .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start(start), .stop(stop)
    );

    assign start_ev = start & ~off;

    ddcx_engine u_eng (
        .clk(clk), .rst(rst), .en(~off), .legacy(legacy), .sda_s(sda_s),
        .scl_rise(scl_rise), .scl_fall(scl_fall), .start(start), .stop(stop),
        .own_addr(own_addr), .tx_byte(data_q), .tx_dir(tx_dir), .ev(ev),
        .rx_byte(rx_byte), .rx_we(rx_we), .ack_we(ack_we), .ack_val(ack_val),
        .sda_oe(eng_oe)
    );

    ddcx_regs u_regs (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .scl_s(scl_s),
        .start_ev(start_ev), .ev(ev), .rx_byte(rx_byte), .rx_we(rx_we),
        .ack_we(ack_we), .ack_val(ack_val), .legacy(legacy), .off(off),
        .own_addr(own_addr), .data_q(data_q), .tx_dir(tx_dir),
        .stop_flag(stop_flag), .pend(pend), .ien(ien), .irq(irq)
    );

    assign sda_oe  = eng_oe & ~off;
    assign pin_sel = ~off;
endmodule

// File: rtl/ddcx_slave_chk.sv
module ddcx_slave_chk
    import ddcx_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic       reg_wr,
    input logic [2:0] reg_addr,
    input logic [7:0] reg_wdata,
    input logic       irq,
    input logic       legacy,
    input logic       off,
    input logic       start_ev,
    input logic       scl_s,
    input logic       stop_flag,
    input logic [2:0] pend,
    input logic [2:0] ien
);
    // R2: mode bit drops only after a recognized START
    a_r2_drop_on_start: assert property (@(posedge clk) disable iff (rst)
        $fell(legacy) |-> $past(start_ev));

    // R3: mode bit rises only from a write made while clock line high
    a_r3_force_scl_high: assert property (@(posedge clk) disable iff (rst)
        $rose(legacy) |-> $past(scl_s) && $past(reg_wr) && $past(reg_addr) == OFF_CTRL);

    // R8: stop status is sticky until a clearing write
    a_r8_stop_sticky: assert property (@(posedge clk) disable iff (rst)
        (stop_flag && !(reg_wr && reg_addr == OFF_STAT && reg_wdata[BIT_STOP])) |=> stop_flag);

    // R9: request needs an enabled source and a pending flag
    a_r9_irq_needs_enable: assert property (@(posedge clk) disable iff (rst)
        irq |-> (ien != 3'b000) && (pend != 3'b000));

    // R10: mode held while line function is off
    a_r10_off_mode_held: assert property (@(posedge clk) disable iff (rst)
        (off && legacy) |=> legacy);
endmodule

bind ddcx_slave ddcx_slave_chk u_chk (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .irq(irq), .legacy(legacy), .off(off),
    .start_ev(start_ev), .scl_s(scl_s), .stop_flag(stop_flag),
    .pend(pend), .ien(ien)
);

// File: tb/ddcx_slave_test.sv
module ddcx_slave_test;
    localparam int Q = 8;
    // {address byte, expected acknowledge}
    localparam logic [8:0] VECS [0:4] = '{9'h141, 9'h144, 9'h040, 9'h1C0, 9'h141};

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       reg_wr = 1'b0;
    logic [2:0] reg_addr = 3'd0;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic       scl_m = 1'b1, sda_m = 1'b1;
    logic       sda_oe, pin_sel, irq, sda_bus;
    int         total = 0, bad = 0;
    logic       done = 1'b0;

    assign sda_bus = sda_m & ~sda_oe;
    always #5 clk = ~clk;

    ddcx_slave uut (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .scl_in(scl_m),
        .sda_in(sda_bus), .sda_oe(sda_oe), .pin_sel(pin_sel), .irq(irq)
    );

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        tick(1);
        reg_wr = 1'b0;
    endtask

    task automatic rd_chk(input string tag, input logic [2:0] a, input logic [7:0] exp);
        reg_addr = a; #1;
        chk(tag, reg_rdata, exp);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; scl_m = 1'b1; tick(Q);
        sda_m = 1'b0; tick(Q);
        scl_m = 1'b0; tick(Q);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; tick(Q);
        scl_m = 1'b1; tick(Q);
        sda_m = 1'b1; tick(Q);
    endtask

    task automatic clock_bit(input logic b, output logic seen);
        sda_m = b; tick(Q);
        scl_m = 1'b1; tick(Q);
        seen = sda_bus;
        scl_m = 1'b0; tick(Q);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic acked);
        logic s;
        for (int i = 7; i >= 0; i--) clock_bit(b[i], s);
        clock_bit(1'b1, s);
        acked = ~s;
    endtask

    task automatic read_byte(output logic [7:0] b);
        logic s;
        for (int i = 7; i >= 0; i--) begin
            clock_bit(1'b1, s);
            b[i] = s;
        end
    endtask

    task automatic host_ack(input logic a);
        logic s;
        clock_bit(~a, s);
        sda_m = 1'b1;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic       ak;
        logic [7:0] b;
        tick(4);
        rst = 1'b0;
        tick(2);
        // R1 reset state
        rd_chk("R1 ctrl", 3'd0, 8'h03);
        rd_chk("R1 ien", 3'd1, 8'h00);
        rd_chk("R1 pend", 3'd2, 8'h00);
        rd_chk("R1 iclr", 3'd3, 8'h00);
        rd_chk("R1 sadr", 3'd4, 8'hFF);
        rd_chk("R1 data", 3'd5, 8'h00);
        rd_chk("R1 stat", 3'd6, 8'h00);
        rd_chk("R1 spare", 3'd7, 8'h00);
        chk("R1 pins", {5'b0, pin_sel, sda_oe, irq}, 8'h00);

        // R10 line function off: traffic to the reset address is ignored
        bus_start();
        send_byte(8'hFE, ak);
        chk("R10 no ack while off", {7'b0, ak}, 8'h00);
        bus_stop();
        rd_chk("R10 mode kept", 3'd0, 8'h03);
        rd_chk("R10 no flags", 3'd2, 8'h00);
        rd_chk("R10 no stop status", 3'd6, 8'h00);
        chk("R10 pin_sel low", {7'b0, pin_sel}, 8'h00);

        wr(3'd0, 8'h01);
        wr(3'd1, 8'h07);
        wr(3'd4, 8'hA0);
        chk("R10 pin_sel high", {7'b0, pin_sel}, 8'h01);
        rd_chk("R2 legacy before start", 3'd0, 8'h01);

        // R4 address table
        for (int v = 0; v < 5; v++) begin
            bus_start();
            if (v == 0) rd_chk("R2 cleared by start", 3'd0, 8'h00);
            send_byte(VECS[v][8:1], ak);
            chk($sformatf("R4 ack vec%0d", v), {7'b0, ak}, {7'b0, VECS[v][0]});
            rd_chk($sformatf("R4 pend vec%0d", v), 3'd2, {5'b0, VECS[v][0], 2'b00});
            bus_stop();
            rd_chk($sformatf("R8 stop status vec%0d", v), 3'd6, 8'h04);
            wr(3'd3, 8'h07);
            wr(3'd6, 8'h04);
        end

        // R3 forced legacy mode only with clock line high
        bus_start();
        wr(3'd0, 8'h01);
        rd_chk("R3 ignored with scl low", 3'd0, 8'h00);
        bus_stop();
        wr(3'd0, 8'h01);
        rd_chk("R3 accepted with scl high", 3'd0, 8'h01);
        wr(3'd3, 8'h07);
        wr(3'd6, 8'h04);

        // R5 write direction
        bus_start();
        send_byte(8'hA0, ak);
        chk("R5 addr ack", {7'b0, ak}, 8'h01);
        send_byte(8'h5A, ak);
        chk("R5 byte ack", {7'b0, ak}, 8'h01);
        rd_chk("R5 data 5A", 3'd5, 8'h5A);
        rd_chk("R5 pend", 3'd2, 8'h06);
        chk("R9 irq set", {7'b0, irq}, 8'h01);
        send_byte(8'hC3, ak);
        chk("R5 byte2 ack", {7'b0, ak}, 8'h01);
        rd_chk("R5 data C3", 3'd5, 8'hC3);
        bus_stop();
        rd_chk("R8 stop pend", 3'd2, 8'h07);

        // R9 enables and clearing
        wr(3'd1, 8'h00);
        chk("R9 irq masked", {7'b0, irq}, 8'h00);
        wr(3'd1, 8'h01);
        chk("R9 irq stop only", {7'b0, irq}, 8'h01);
        wr(3'd3, 8'h01);
        rd_chk("R9 clear one", 3'd2, 8'h06);
        chk("R9 irq gone", {7'b0, irq}, 8'h00);
        wr(3'd3, 8'h06);
        rd_chk("R9 clear rest", 3'd2, 8'h00);
        wr(3'd1, 8'h07);

        // R8 sticky status
        tick(20);
        rd_chk("R8 still set", 3'd6, 8'h04);
        wr(3'd6, 8'h04);
        rd_chk("R8 cleared", 3'd6, 8'h00);

        // R6 / R7 read direction
        wr(3'd5, 8'h96);
        wr(3'd6, 8'h01);
        bus_start();
        send_byte(8'hA1, ak);
        chk("R6 read addr ack", {7'b0, ak}, 8'h01);
        read_byte(b);
        chk("R6 first byte", b, 8'h96);
        wr(3'd5, 8'h3C);
        host_ack(1'b1);
        rd_chk("R7 ack stored", 3'd6, 8'h03);
        rd_chk("R7 byte done pend", 3'd2, 8'h06);
        read_byte(b);
        chk("R6 reloaded byte", b, 8'h3C);
        host_ack(1'b0);
        rd_chk("R7 nack stored", 3'd6, 8'h01);
        chk("R7 released", {7'b0, sda_oe}, 8'h00);
        read_byte(b);
        chk("R7 idle after nack", b, 8'hFF);
        bus_stop();
        wr(3'd3, 8'h07);
        wr(3'd6, 8'h04);

        // R6 transmit disabled
        wr(3'd5, 8'h00);
        bus_start();
        send_byte(8'hA1, ak);
        chk("R6 addr ack tx off", {7'b0, ak}, 8'h01);
        read_byte(b);
        chk("R6 not driven", b, 8'hFF);
        host_ack(1'b0);
        bus_stop();

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule